// File: doc/BRIEF.md
# Interrupt-to-Message Bridge

This block gathers a set of peripheral interrupt lines (up to 64) and turns activity on each of them into a message request toward a host link. A message is a single vector index presented on a valid/ready pair. It stays on the output until the consumer takes it. The host-side address/data tables and the link transport belong to the consumer, not to this block.

Each vector has its own configuration word on a 32-bit register bus. The word holds an enable bit and a mode bit. In edge mode, every rising edge of the line produces one message. In level mode, the vector produces one message and then stays silent until software writes an acknowledge bit. Two further bits are write-only strobes: acknowledge, and a software test trigger that behaves like a rising edge. Each configuration word can be reached through three address windows:
- a plain window, where a write replaces the word;
- a set window, where each 1 written turns the matching bit on;
- a clear window, where each 1 written turns the matching bit off.

Because of the set and clear windows, software never needs a read-modify-write. Two read-only words report the sampled state of the input lines. When several vectors are pending at once, they are served in rotating order.

Top module: `irq_msg_bridge`

## Requirements
- R1: After synchronous reset, every enable and mode bit is 0, `msg_valid` is 0, and `reg_rdata` is 0.
- R2: The configuration word of vector n is at byte offset 0x8 + 4·n. Its bits are: bit 0 enable, bit 1 test, bit 2 acknowledge, bit 3 level mode. A plain write replaces bits 0 and 3. A read returns bits 0 and 3, and bits 1 and 2 always read 0. `reg_rdata` takes the read value in the cycle after `reg_rd`.
- R3: A write at offset 0x800 + 0x8 + 4·n turns on the enable and mode bits of vector n that are 1 in the data. Bits written as 0 are left as they were.
- R4: A write at offset 0xC00 + 0x8 + 4·n turns off the enable and mode bits of vector n that are 1 in the data. Bits written as 0 are left as they were.
- R5: A vector whose enable bit is 0 never produces a message.
- R6: In edge mode (bit 3 = 0), each rising edge of the line produces exactly one message. A line that stays high produces no further message.
- R7: In level mode (bit 3 = 1), a high line produces one message. No further message follows until software writes 1 to bit 2 through the plain or set window. After that write, a line that is still high produces one new message. A line that is low produces none.
- R8: Writing 1 to bit 2 or to bit 1 has a single effect. Bit 1 acts as one rising edge on that vector.
- R9: Offset 0x108 reads the sampled lines of vectors 0–31 (bit i = vector i). Offset 0x10C reads the sampled lines of vectors 32–63 (bit i = vector 32+i).
- R10: Pending vectors are granted in rotating order. The search starts at the vector after the one granted last.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and `msg_vec` does not change.
- R12: Writes to offsets that map to no configuration word change no state. This covers the window at 0x400, offsets below 0x8, and the status words. Reads of such offsets return 0, and so do reads in the set and clear windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NVEC | Peripheral interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after reg_rd |
| msg_valid | output | 1 | A message request is offered |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_vec | output | VW | Vector index of the offered message |

## Verification
The assertions assume that the interrupt lines are already synchronous to `clk`. They also assume that `reg_wr` and `reg_rd` are not raised together, and that a consumer holding `msg_ready` low may do so for any length of time. The bench drives all inputs only on falling edges and uses one register access at a time. It allows enough idle cycles after each line change for the two sampling stages and the arbiter to settle, then counts the messages actually accepted. Line changes are spaced several cycles apart, so that each rising edge is seen on its own.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int CFG_BASE  = 8;
  localparam int STAT_LO   = 'h108;
  localparam int STAT_HI   = 'h10C;
  localparam int B_EN      = 0;
  localparam int B_TEST    = 1;
  localparam int B_IACK    = 2;
  localparam int B_LVL     = 3;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'b00,
    WIN_NONE  = 2'b01,
    WIN_SET   = 2'b10,
    WIN_CLR   = 2'b11
  } win_e;
endpackage

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int NVEC = 64,
  parameter int AW   = 12,
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NVEC-1:0] src_stat,
  output logic [NVEC-1:0] cfg_en,
  output logic [NVEC-1:0] cfg_lvl,
  output logic [NVEC-1:0] test_p,
  output logic [NVEC-1:0] iack_p
);
  win_e        win;
  logic [9:0]  off;
  logic [9:0]  rel;
  logic        hit_cfg;
  logic [VW-1:0] vidx;
  logic [63:0] stat64;
  logic [31:0] rd_val;
  logic        unused_wd;

  assign win       = win_e'(reg_addr[AW-1:AW-2]);
  assign off       = reg_addr[9:0];
  assign rel       = off - 10'(CFG_BASE);
  assign vidx      = rel[VW+1:2];
  assign hit_cfg   = (off >= 10'(CFG_BASE)) && (off < 10'(CFG_BASE + 4*NVEC)) && (off[1:0] == 2'b00);
  assign unused_wd = ^reg_wdata[31:4];

  always_comb begin
    stat64 = '0;
    stat64[NVEC-1:0] = src_stat;
  end

  always_comb begin
    rd_val = '0;
    if (win == WIN_PLAIN) begin
      if (hit_cfg) begin
        rd_val[B_EN]  = cfg_en[vidx];
        rd_val[B_LVL] = cfg_lvl[vidx];
      end else if (off == 10'(STAT_LO)) begin
        rd_val = stat64[31:0];
      end else if (off == 10'(STAT_HI)) begin
        rd_val = stat64[63:32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= '0;
      cfg_lvl   <= '0;
      test_p    <= '0;
      iack_p    <= '0;
      reg_rdata <= '0;
    end else begin
      test_p <= '0;
      iack_p <= '0;
      if (reg_rd) reg_rdata <= rd_val;
      if (reg_wr && hit_cfg) begin
        case (win)
          WIN_PLAIN: begin
            cfg_en[vidx]  <= reg_wdata[B_EN];
            cfg_lvl[vidx] <= reg_wdata[B_LVL];
            test_p[vidx]  <= reg_wdata[B_TEST];
            iack_p[vidx]  <= reg_wdata[B_IACK];
          end
          WIN_SET: begin
            if (reg_wdata[B_EN])  cfg_en[vidx]  <= 1'b1;
            if (reg_wdata[B_LVL]) cfg_lvl[vidx] <= 1'b1;
            test_p[vidx] <= reg_wdata[B_TEST];
            iack_p[vidx] <= reg_wdata[B_IACK];
          end
          WIN_CLR: begin
            if (reg_wdata[B_EN])  cfg_en[vidx]  <= 1'b0;
            if (reg_wdata[B_LVL]) cfg_lvl[vidx] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(cfg_en) && $stable(cfg_lvl))) else $error("cfg changed without write"); // R12
endmodule

// File: rtl/irq_msg_vector.sv
module irq_msg_vector (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic en,
  input  logic lvl,
  input  logic test_p,
  input  logic iack_p,
  input  logic grant,
  output logic pend,
  output logic src_q
);
  logic src_prev;
  logic pend_q;
  logic waiting;
  logic set_ev;

  assign set_ev = ~waiting & (test_p | (lvl ? (src_q & ~grant) : (src_q & ~src_prev)));
  assign pend   = pend_q & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= 1'b0;
      src_prev <= 1'b0;
      pend_q   <= 1'b0;
      waiting  <= 1'b0;
    end else begin
      src_q    <= src;
      src_prev <= src_q;
      pend_q   <= en & ((pend_q & ~grant) | set_ev);
      if (!en || !lvl || iack_p) waiting <= 1'b0;
      else if (grant)            waiting <= 1'b1;
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en |-> !grant) else $error("disabled vector granted"); // R5
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !grant) else $error("level vector granted before ack"); // R7
  AST_GRANT_PEND: assert property (@(posedge clk) disable iff (rst)
    grant |-> pend) else $error("grant without pending"); // R10
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
  parameter int NVEC = 64,
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] pend,
  input  logic            msg_ready,
  output logic            msg_valid,
  output logic [VW-1:0]   msg_vec,
  output logic [NVEC-1:0] grant
);
  logic [VW-1:0] ptr;
  logic [VW-1:0] pick;
  logic          found;
  logic          load;
  logic [NVEC-1:0] one;

  assign one = NVEC'(1);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NVEC; i++) begin
      int j;
      j = int'(ptr) + i;
      if (j >= NVEC) j = j - NVEC;
      if (!found && pend[j]) begin
        found = 1'b1;
        pick  = VW'(j);
      end
    end
  end

  assign load  = found && (!msg_valid || msg_ready);
  assign grant = load ? (one << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_vec   <= '0;
      ptr       <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_vec   <= pick;
      ptr       <= (int'(pick) == NVEC-1) ? '0 : pick + 1'b1;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) else $error("multiple grants"); // R10
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec))) else $error("offer dropped"); // R11
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge #(
  parameter int NVEC = 64,
  parameter int AW   = 12,
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] irq_src,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [VW-1:0]   msg_vec
);
  logic [NVEC-1:0] cfg_en, cfg_lvl, test_p, iack_p;
  logic [NVEC-1:0] pend, grant, src_q;

  irq_msg_regs #(.NVEC(NVEC), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_stat(src_q), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
    .test_p(test_p), .iack_p(iack_p)
  );

  for (genvar n = 0; n < NVEC; n++) begin : g_vec
    irq_msg_vector u_vec (
      .clk(clk), .rst(rst), .src(irq_src[n]), .en(cfg_en[n]), .lvl(cfg_lvl[n]),
      .test_p(test_p[n]), .iack_p(iack_p[n]), .grant(grant[n]),
      .pend(pend[n]), .src_q(src_q[n])
    );
  end

  irq_msg_arb #(.NVEC(NVEC)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vec(msg_vec), .grant(grant)
  );
endmodule

// File: tb/irq_msg_bridge_tb.sv
module irq_msg_bridge_tb;
  localparam int NVEC = 64;
  localparam int AW   = 12;
  localparam int VW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NVEC-1:0] irq_src = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_valid;
  logic msg_ready = 1'b1;
  logic [VW-1:0] msg_vec;

  int n_chk = 0;
  int n_bad = 0;
  int mq[$];

  always #5 clk = ~clk;

  irq_msg_bridge #(.NVEC(NVEC), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec)
  );

  always @(posedge clk)
    if (!rst && msg_valid && msg_ready) mq.push_back(int'(msg_vec));

  function automatic logic [11:0] cfg_a(int n);
    return 12'(8 + 4*n);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
    chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 0);
    rd(cfg_a(63), d);
    chk(d == 32'h0, "R1 cfg63", d, 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    wr(cfg_a(5), 32'hF);
    rd(cfg_a(5), d);
    chk(d == 32'h9, "R2 readback strips strobes (R8)", d, 32'h9);
    wr(cfg_a(5), 32'h0);
    rd(cfg_a(5), d);
    chk(d == 32'h0, "R2 plain write replaces", d, 0);
    mq.delete();
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(12'h800 | cfg_a(3), 32'h1);
    wr(12'h800 | cfg_a(3), 32'h8);
    rd(cfg_a(3), d);
    chk(d == 32'h9, "R3 set alias ORs", d, 32'h9);
    wr(12'hC00 | cfg_a(3), 32'h1);
    rd(cfg_a(3), d);
    chk(d == 32'h8, "R4 clear alias", d, 32'h8);
    wr(12'hC00 | cfg_a(3), 32'h8);
  endtask

  task automatic t_disabled;
    mq.delete();
    wr(cfg_a(7), 32'h8);
    @(negedge clk) irq_src[7] = 1'b1;
    idle(20);
    irq_src[7] = 1'b0;
    chk(mq.size() == 0, "R5 disabled silent", mq.size(), 0);
    wr(cfg_a(7), 32'h0);
  endtask

  task automatic t_edge;
    mq.delete();
    wr(cfg_a(10), 32'h1);
    @(negedge clk) irq_src[10] = 1'b1;
    idle(20);
    chk(mq.size() == 1, "R6 one msg while held high", mq.size(), 1);
    irq_src[10] = 1'b0;
    idle(5);
    irq_src[10] = 1'b1;
    idle(20);
    chk(mq.size() == 2, "R6 second edge", mq.size(), 2);
    chk(mq.size() == 2 && mq[0] == 10 && mq[1] == 10, "R6 vector index", mq.size() > 0 ? mq[0] : -1, 10);
    irq_src[10] = 1'b0;
    wr(cfg_a(10), 32'h0);
  endtask

  task automatic t_level;
    mq.delete();
    wr(cfg_a(20), 32'h9);
    @(negedge clk) irq_src[20] = 1'b1;
    idle(20);
    chk(mq.size() == 1, "R7 one msg before ack", mq.size(), 1);
    wr(12'h800 | cfg_a(20), 32'h4);
    idle(20);
    chk(mq.size() == 2, "R7 re-armed by ack with line high", mq.size(), 2);
    irq_src[20] = 1'b0;
    idle(3);
    wr(cfg_a(20), 32'hD);
    idle(20);
    chk(mq.size() == 2, "R7 ack with line low adds none", mq.size(), 2);
    wr(cfg_a(20), 32'h0);
  endtask

  task automatic t_test;
    logic [31:0] d;
    mq.delete();
    wr(cfg_a(33), 32'h1);
    wr(12'h800 | cfg_a(33), 32'h2);
    idle(20);
    chk(mq.size() == 1 && mq[0] == 33, "R8 test trigger one msg", mq.size(), 1);
    rd(cfg_a(33), d);
    chk(d == 32'h1, "R8 test self-clears", d, 1);
    wr(cfg_a(33), 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk);
    irq_src = '0;
    irq_src[4] = 1'b1; irq_src[31] = 1'b1; irq_src[40] = 1'b1;
    idle(3);
    rd(12'h108, d);
    chk(d == 32'h8000_0010, "R9 status low", d, 32'h8000_0010);
    rd(12'h10C, d);
    chk(d == 32'h0000_0100, "R9 status high", d, 32'h100);
    irq_src = '0;
    idle(3);
  endtask

  task automatic t_rr;
    mq.delete();
    wr(cfg_a(1), 32'h1); wr(cfg_a(2), 32'h1);
    wr(cfg_a(3), 32'h1); wr(cfg_a(5), 32'h1);
    @(negedge clk);
    msg_ready = 1'b0;
    irq_src[1] = 1'b1; irq_src[2] = 1'b1; irq_src[3] = 1'b1;
    idle(10);
    chk(msg_valid == 1'b1 && msg_vec == 6'd1, "R11 offer present", msg_vec, 1);
    idle(6);
    chk(msg_valid == 1'b1 && msg_vec == 6'd1, "R11 offer held", msg_vec, 1);
    msg_ready = 1'b1;
    idle(20);
    chk(mq.size() == 3 && mq[0] == 1 && mq[1] == 2 && mq[2] == 3, "R10 order 1,2,3", mq.size(), 3);
    irq_src = '0;
    idle(5);
    mq.delete();
    msg_ready = 1'b0;
    irq_src[2] = 1'b1; irq_src[5] = 1'b1;
    idle(10);
    msg_ready = 1'b1;
    idle(20);
    chk(mq.size() == 2 && mq[0] == 5 && mq[1] == 2, "R10 rotation starts after last grant",
        mq.size() > 0 ? mq[0] : -1, 5);
    irq_src = '0;
    wr(cfg_a(1), 0); wr(cfg_a(2), 0); wr(cfg_a(3), 0); wr(cfg_a(5), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h400 | cfg_a(0), 32'h9);
    wr(12'h004, 32'h9);
    wr(12'h108, 32'hFFFF_FFFF);
    rd(cfg_a(0), d);
    chk(d == 32'h0, "R12 unmapped write ignored", d, 0);
    wr(cfg_a(1), 32'h9);
    rd(12'h800 | cfg_a(1), d);
    chk(d == 32'h0, "R12 alias read zero", d, 0);
    rd(12'h004, d);
    chk(d == 32'h0, "R12 low offset read zero", d, 0);
    wr(cfg_a(1), 32'h0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_plain();
    t_alias();
    t_disabled();
    t_edge();
    t_level();
    t_test();
    t_status();
    t_rr();
    t_unmapped();
    idle(5);
    finish_run();
  end
endmodule